// File: doc/BRIEF.md
# Sequential Line Prefetch Buffer

This block sits between a data cache that asks for whole lines and a DRAM-like backing store. A request names a line address. The response returns 32 bytes as four 64-bit words, with word 0 in bits 63:0. The block keeps timing for the store itself. A memory access takes a short time when it falls in the DRAM page that is currently open. It takes a long time when the page is closed or a different page is open.

A software mode pin, `ahead_en`, enables read-ahead. When it is set, each time a response is loaded the block starts fetching the next sequential line into a single-line buffer. A later request for that line is served from the buffer in one clock and does not touch memory. Read-ahead suits one sequential input stream. Scalar or random traffic should run with the mode off.

The cache side uses valid/ready in both directions. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a demand access is in progress and while a response waits to be taken, so at most one request is outstanding. A response is held, with its data unchanged, until `rsp_ready` is seen high on a clock edge. The memory side is a read port. `mem_active` is high while an access runs, and `mem_addr` stays constant for the whole access. `mem_rdata` must show the contents of the line at `mem_addr` during that access.

Top module: `line_prefetch_buf`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_active` is 0. No DRAM page is open, so the first miss takes the closed-page latency.
- R2: A miss to a page other than the open one raises `rsp_valid` after the 23rd clock edge that follows the accepting edge (LAT_OPEN = 23).
- R3: A miss to the open page raises `rsp_valid` after the 7th clock edge that follows the accepting edge (LAT_SAME = 7).
- R4: The page of a line is its line address shifted right by PAGE_W = 6 bits. The open page becomes the page of each memory access when that access starts, whether it is a demand access or a prefetch.
- R5: With `ahead_en` high, on the edge that loads a response the block starts a memory access for line address + 1. Its latency follows R2/R3. When it completes, that line is held in the buffer.
- R6: With `ahead_en` high, a request for the line held in the buffer raises `rsp_valid` one edge after acceptance, and `mem_active` stays 0 for that request.
- R7: While `ahead_en` is low, no prefetch starts and the buffer is emptied. A line prefetched before the mode was switched off and on again is fetched from memory.
- R8: A request accepted while a prefetch is in flight cancels the prefetch and is served at once with its own latency. The cancelled line does not enter the buffer.
- R9: A response with `rsp_ready` low keeps `rsp_valid` high and `rsp_data` stable. `req_ready` stays low from acceptance until the response is taken.
- R10: `rsp_data` equals the memory contents of the requested line.
- R11: The next line after the highest line address is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ahead_en | input | 1 | Read-ahead mode enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | LINE_AW | Requested line address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | LINE_W | Line data, word 0 in the low bits |
| mem_active | output | 1 | Memory access in progress |
| mem_addr | output | LINE_AW | Line address being read |
| mem_rdata | input | LINE_W | Memory contents at `mem_addr` |

## Verification
The assertions assume that `mem_rdata` depends only on `mem_addr`. They also assume the requester keeps `req_addr` steady while `req_valid` waits for `req_ready`. The bench meets both conditions. Its memory is a fixed function of the address, so every line has distinct contents. Its requests are raised only at a falling edge when `req_ready` is high, and they are dropped right after the accepting edge. The bench delays `rsp_ready` for several cycles on chosen responses and toggles the mode pin only between requests.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_AHEAD  = 2'd2
  } lpb_state_e;
endpackage

// File: rtl/lpb_countdown.sv
module lpb_countdown #(
  parameter int CNT_W = 5,
  parameter int MAX_V = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign zero = (cnt == '0);

  // the wait never exceeds the closed-page latency
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_V));
endmodule

// File: rtl/lpb_page_tracker.sv
module lpb_page_tracker #(
  parameter int PG_W     = 20,
  parameter int CNT_W    = 5,
  parameter int LAT_SAME = 7,
  parameter int LAT_OPEN = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PG_W-1:0]  probe_page,
  input  logic             open_en,
  output logic [CNT_W-1:0] wait_val
);
  logic [PG_W-1:0] open_page;
  logic            page_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_live <= 1'b0;
      open_page <= '0;
    end else if (open_en) begin
      page_live <= 1'b1;
      open_page <= probe_page;
    end
  end

  assign wait_val = (page_live && open_page == probe_page) ?
                    CNT_W'(LAT_SAME - 1) : CNT_W'(LAT_OPEN - 1);

  assert_page_opened_R4: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |=> page_live);
endmodule

// File: rtl/lpb_line_buf.sv
module lpb_line_buf #(
  parameter int LINE_AW = 26,
  parameter int LINE_W  = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill,
  input  logic [LINE_AW-1:0] fill_tag,
  input  logic [LINE_W-1:0]  fill_data,
  input  logic               clear,
  input  logic [LINE_AW-1:0] look_addr,
  output logic               hit,
  output logic [LINE_W-1:0]  held_data
);
  logic               held_ok;
  logic [LINE_AW-1:0] held_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_ok  <= 1'b0;
      held_tag <= '0;
    end else if (clear) begin
      held_ok  <= 1'b0;
    end else if (fill) begin
      held_ok  <= 1'b1;
      held_tag <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) held_data <= fill_data;
  end

  assign hit = held_ok && (held_tag == look_addr);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !held_ok);
  assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !clear) |=> held_ok && held_tag == $past(fill_tag));
endmodule

// File: rtl/line_prefetch_buf.sv
module line_prefetch_buf
  import lpb_pkg::*;
#(
  parameter int LINE_AW    = 26,
  parameter int WORD_W     = 64,
  parameter int LINE_WORDS = 4,
  parameter int PAGE_W     = 6,
  parameter int LAT_SAME   = 7,
  parameter int LAT_OPEN   = 23,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ahead_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LINE_AW-1:0] req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [LINE_W-1:0]  rsp_data,
  output logic               mem_active,
  output logic [LINE_AW-1:0] mem_addr,
  input  logic [LINE_W-1:0]  mem_rdata
);
  localparam int CNT_W = $clog2(LAT_OPEN);
  localparam int PG_W  = LINE_AW - PAGE_W;

  lpb_state_e         state;
  logic [LINE_AW-1:0] cur_addr;
  logic [LINE_AW-1:0] next_addr;
  logic               from_buf;
  logic               accept;
  logic               buf_hit;
  logic               hit;
  logic               done;
  logic               fill_end;
  logic               pf_start;
  logic               pf_fill;
  logic [LINE_AW-1:0] probe_addr;
  logic [CNT_W-1:0]   wait_val;
  logic [CNT_W-1:0]   load_val;
  logic [LINE_W-1:0]  buf_data;

  assign req_ready  = (state != ST_DEMAND) && !rsp_valid;
  assign accept     = req_valid && req_ready;
  assign hit        = ahead_en && buf_hit;
  assign next_addr  = cur_addr + LINE_AW'(1);
  assign fill_end   = (state == ST_DEMAND) && done;
  assign pf_start   = fill_end && ahead_en;
  assign pf_fill    = (state == ST_AHEAD) && done && ahead_en && !accept;
  assign probe_addr = fill_end ? next_addr : req_addr;
  assign load_val   = (accept && hit) ? '0 : wait_val;

  lpb_countdown #(.CNT_W(CNT_W), .MAX_V(LAT_OPEN - 1)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept || pf_start),
    .load_val (load_val),
    .zero     (done)
  );

  lpb_page_tracker #(.PG_W(PG_W), .CNT_W(CNT_W), .LAT_SAME(LAT_SAME),
                     .LAT_OPEN(LAT_OPEN)) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_page (probe_addr[LINE_AW-1:PAGE_W]),
    .open_en    ((accept && !hit) || pf_start),
    .wait_val   (wait_val)
  );

  lpb_line_buf #(.LINE_AW(LINE_AW), .LINE_W(LINE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (pf_fill),
    .fill_tag  (mem_addr),
    .fill_data (mem_rdata),
    .clear     (!ahead_en),
    .look_addr (req_addr),
    .hit       (buf_hit),
    .held_data (buf_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      from_buf   <= 1'b0;
      mem_active <= 1'b0;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        state      <= ST_DEMAND;
        cur_addr   <= req_addr;
        from_buf   <= hit;
        mem_active <= !hit;
        if (!hit) mem_addr <= req_addr;
      end else if (fill_end) begin
        rsp_valid  <= 1'b1;
        state      <= ahead_en ? ST_AHEAD : ST_IDLE;
        mem_active <= ahead_en;
        if (ahead_en) mem_addr <= next_addr;
      end else if (state == ST_AHEAD && (!ahead_en || done)) begin
        state      <= ST_IDLE;
        mem_active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_end) rsp_data <= from_buf ? buf_data : mem_rdata;
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_hit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> !mem_active);
  assert_hit_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> ##1 rsp_valid);
  assert_next_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && $past(ahead_en)) |-> mem_active && mem_addr == $past(next_addr));
endmodule

// File: tb/sim_line_prefetch_buf.sv
`timescale 1ns/1ps
module sim_line_prefetch_buf;
  localparam int AW = 26;
  localparam int PW = 6;
  localparam int LW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ahead_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [LW-1:0] rsp_data;
  logic          mem_active;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    logic [LW-1:0] l;
    for (int i = 0; i < 4; i++) l[i*64 +: 64] = {32'(a), 16'hC0DE, 16'(i)};
    return l;
  endfunction

  assign mem_rdata = line_of(mem_addr);

  line_prefetch_buf u0 (
    .clk(clk), .rst_n(rst_n), .ahead_en(ahead_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_active(mem_active), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic wrap_up;
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            m_mode;   // 0 idle, 1 demand, 2 read-ahead
  int            m_left;
  logic [AW-1:0] m_cur, m_mema, m_btag, m_raddr, m_pg;
  bit            m_memon, m_pgok, m_bok, m_rv;

  function automatic int page_wait(input logic [AW-1:0] a);
    return (m_pgok && (a >> PW) == m_pg) ? 7 : 23;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_memon = 0; m_pgok = 0; m_bok = 0; m_rv = 0;
      m_cur = '0; m_mema = '0; m_btag = '0; m_raddr = '0; m_pg = '0;
    end else begin
      bit rdy, acc, hit, drain;
      logic [AW-1:0] nx;
      rdy   = (m_mode != 1) && !m_rv;
      acc   = req_valid && rdy;
      hit   = ahead_en && m_bok && (m_btag == req_addr);
      drain = m_rv && rsp_ready;
      if (drain) m_rv = 0;
      if (m_mode == 1) begin
        if (m_left == 0) begin
          m_rv = 1; m_raddr = m_cur;
          if (ahead_en) begin
            nx = m_cur + AW'(1);
            m_left = page_wait(nx) - 1;
            m_pg = nx >> PW; m_pgok = 1;
            m_mema = nx; m_memon = 1; m_mode = 2;
          end else begin
            m_mode = 0; m_memon = 0;
          end
        end else m_left--;
      end else if (acc) begin
        m_mode = 1; m_cur = req_addr;
        if (hit) begin
          m_left = 0; m_memon = 0;
        end else begin
          m_left = page_wait(req_addr) - 1;
          m_pg = req_addr >> PW; m_pgok = 1;
          m_mema = req_addr; m_memon = 1;
        end
      end else if (m_mode == 2) begin
        if (!ahead_en) begin
          m_mode = 0; m_memon = 0;
        end else if (m_left == 0) begin
          m_bok = 1; m_btag = m_mema; m_mode = 0; m_memon = 0;
        end else m_left--;
      end
      if (!ahead_en) m_bok = 0;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(req_ready == ((m_mode != 1) && !m_rv),
          $sformatf("R9 req_ready actual %0b expected %0b", req_ready, (m_mode != 1) && !m_rv));
      chk(rsp_valid == m_rv,
          $sformatf("R2 rsp_valid actual %0b expected %0b", rsp_valid, m_rv));
      if (m_rv)
        chk(rsp_data == line_of(m_raddr),
            $sformatf("R10 rsp_data actual %h expected %h", rsp_data, line_of(m_raddr)));
      chk(mem_active == m_memon,
          $sformatf("R6 mem_active actual %0b expected %0b", mem_active, m_memon));
      if (m_memon)
        chk(mem_addr == m_mema,
            $sformatf("R5 mem_addr actual %h expected %h", mem_addr, m_mema));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual %0d cycles expected below 100000", cyc);
      wrap_up();
    end
  end

  // issue one request, measure its latency, optionally stall the response
  task automatic do_req(input logic [AW-1:0] a, input int exp_lat, input int hold,
                        input string tag);
    int k;
    logic [LW-1:0] got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!rsp_valid && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(k == exp_lat, $sformatf("%s latency line %h actual %0d expected %0d", tag, a, k, exp_lat));
    chk(rsp_data == line_of(a),
        $sformatf("R10 data line %h actual %h expected %h", a, rsp_data, line_of(a)));
    got = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == got && !req_ready,
          $sformatf("R9 hold cycle %0d actual v=%0b rdy=%0b expected v=1 rdy=0", h, rsp_valid, req_ready));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_active,
        $sformatf("R1 reset state actual rdy=%0b v=%0b mem=%0b expected 1 0 0", req_ready, rsp_valid, mem_active));

    // mode off: page timing only
    do_req(AW'('h40), 23, 0, "R1");
    do_req(AW'('h41), 7, 0, "R3");
    do_req(AW'('h7F), 7, 3, "R4");
    do_req(AW'('h80), 23, 0, "R4");

    // read-ahead stream
    ahead_en = 1'b1;
    do_req(AW'('h100), 23, 0, "R2");
    idle(10);
    do_req(AW'('h101), 1, 0, "R6");
    idle(10);
    do_req(AW'('h102), 1, 2, "R5");
    idle(10);
    do_req(AW'('h103), 1, 0, "R5");

    // demand miss while prefetch of 0x104 is in flight
    do_req(AW'('h500), 23, 0, "R8");
    idle(10);
    do_req(AW'('h104), 23, 0, "R8");
    idle(10);

    // mode toggled off and on empties the buffer
    ahead_en = 1'b0;
    idle(2);
    ahead_en = 1'b1;
    idle(1);
    do_req(AW'('h105), 7, 0, "R7");
    idle(10);
    ahead_en = 1'b0;
    idle(1);
    do_req(AW'('h106), 7, 0, "R7");
    idle(5);
    chk(!mem_active, $sformatf("R7 no prefetch actual mem_active=%0b expected 0", mem_active));

    // wrap from the top line to line 0
    ahead_en = 1'b1;
    do_req('1, 23, 0, "R11");
    idle(30);
    do_req('0, 1, 0, "R11");

    idle(5);
    wrap_up();
  end
endmodule